// File: doc/BRIEF.md
# Multiprocessor External Interrupt Distributor

This block sits between a set of external interrupt request lines and a cluster of processor cores. Each distributed line carries a global enable bit and a per-line steering mask with one bit per core. A line reaches core `c` only when the line is asserted, its enable bit is set and bit `c` of its steering mask is set. The result is a flat vector of requests, grouped by core, that feeds each core's local interrupt controller.

Software manages the enable bits through two write-only views of the same enable vector. One view only raises bits and the other only lowers them. This lets separate cores change individual lines without a read-modify-write sequence. The two lowest external inputs carry inter-processor interrupts. They skip the distributor and leave the block unchanged on a separate bypass output. Distributed line `k` is therefore taken from external input `k+2`.

Top module: `irq_distributor`

## Requirements
- R1: While reset is held, and right after it, every enable bit is 0, every steering mask reads 1 (core 0 only) and every request output is 0.
- R2: A write to offset 0 (enable-lower view) clears each enable bit whose data bit is 1. Enable bits whose data bit is 0 keep their value. Enable bits change only through offset 0 or offset 1.
- R3: A write to offset 1 (enable-raise view) sets each enable bit whose data bit is 1. Enable bits whose data bit is 0 keep their value. Data bits at or above the line count have no effect.
- R4: A read of offset 0 or offset 1 returns the current enable vector in bits [NUM_LINES-1:0]. All other read bits are zero.
- R5: Offset 2+k holds the steering mask of line k, and bit c of the mask selects core c. A write loads data bits [NUM_CORES-1:0] into the mask. Higher data bits are dropped, and they read back as zero. A mask changes only when its own offset is written.
- R6: Request output bit `c*NUM_LINES+k` equals external input `k+2` AND enable bit k AND mask bit c of line k. With the default registered variant, the output follows its inputs after one clock edge.
- R7: External inputs 0 and 1 appear unchanged on the bypass output `ipi_o`, and they never influence any request output.
- R8: A mask with several bits set delivers the line to all of the selected cores. An all-zero mask delivers the line to no core.
- R9: Offsets 2+NUM_LINES and above are unmapped. Writes to them change no enable bit and no mask, and reads from them return zero.
- R10: When an external line drops, its request to every core drops one clock edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_irq_i | input | NUM_LINES+2 | External level requests; bits 1:0 are inter-processor lines |
| ipi_o | output | 2 | Bypass copy of the inter-processor inputs |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register word offset |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Register read data for reg_addr_i (combinational) |
| core_irq_o | output | NUM_CORES*NUM_LINES | Routed requests; bit c*NUM_LINES+k is line k to core c |

## Verification
The routing function is exercised with several input patterns:
- Every line high with no enable set separates input gating from enable gating.
- An alternating input pattern with all lines enabled shows that each line is masked on its own, with no mixing between neighbours.
- A line steered to core 2, a broadcast mask and an all-zero mask tell single-target, multi-target and null delivery apart.

The write sequences separate the roles of the two enable views: a mixed-bit raise followed by a sparse lower must leave the untouched bits alone. Toggling only the inter-processor inputs, writing to unmapped offsets and dropping the lines for one edge show that the bypass, the unmapped space and the one-edge release behave as required.

// File: rtl/irqd_pkg.sv
package irqd_pkg;

  localparam int unsigned IPI_LINES  = 2;
  localparam int unsigned OFS_EN_CLR = 0;
  localparam int unsigned OFS_EN_SET = 1;
  localparam int unsigned OFS_ROUTE0 = 2;

  typedef enum logic [1:0] {
    ACC_NONE   = 2'd0,
    ACC_EN_CLR = 2'd1,
    ACC_EN_SET = 2'd2,
    ACC_ROUTE  = 2'd3
  } acc_kind_e;

  // Sorts a register word offset into the kind of access it addresses.
  function automatic acc_kind_e classify(input int unsigned offset,
                                         input int unsigned n_lines);
    if (offset == OFS_EN_CLR) return ACC_EN_CLR;
    if (offset == OFS_EN_SET) return ACC_EN_SET;
    if ((offset >= OFS_ROUTE0) && (offset < OFS_ROUTE0 + n_lines)) return ACC_ROUTE;
    return ACC_NONE;
  endfunction

  // Next value of one enable bit: raise wins only on the raise view,
  // lower wins only on the lower view, zero data bits keep the bit.
  function automatic logic next_enable(input logic cur,
                                       input logic data_bit,
                                       input logic raise,
                                       input logic lower);
    logic nxt;
    nxt = cur;
    if (raise && data_bit) nxt = 1'b1;
    if (lower && data_bit) nxt = 1'b0;
    return nxt;
  endfunction

  // Delivery condition for one (line, core) pair.
  function automatic logic deliver(input logic line_lvl,
                                   input logic line_en,
                                   input logic core_sel);
    return line_lvl & line_en & core_sel;
  endfunction

endpackage

// File: rtl/irqd_decode.sv
module irqd_decode
  import irqd_pkg::*;
#(
  parameter int unsigned ADDR_W    = 5,
  parameter int unsigned NUM_LINES = 8,
  parameter int unsigned LINE_W    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_we,
  input  logic [ADDR_W-1:0]     reg_addr,
  output acc_kind_e             kind,
  output logic [LINE_W-1:0]     line_idx,
  output logic                  clr_stb,
  output logic                  set_stb,
  output logic [NUM_LINES-1:0]  route_stb
);

  logic [ADDR_W-1:0] route_ofs;

  always_comb begin
    kind      = classify(32'(reg_addr), NUM_LINES);
    route_ofs = reg_addr - ADDR_W'(OFS_ROUTE0);
    line_idx  = LINE_W'(route_ofs);
  end

  assign clr_stb = reg_we && (kind == ACC_EN_CLR);
  assign set_stb = reg_we && (kind == ACC_EN_SET);

  for (genvar k = 0; k < NUM_LINES; k++) begin : g_stb
    assign route_stb[k] = reg_we && (kind == ACC_ROUTE) && (line_idx == LINE_W'(k));
  end

  // A write targets at most one register.
  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({clr_stb, set_stb, route_stb})); // R9

  // No register strobe without a write.
  AST_STROBE_NEEDS_WE: assert property (@(posedge clk) disable iff (!rst_n)
    (|{clr_stb, set_stb, route_stb}) |-> reg_we); // R9

endmodule

// File: rtl/irqd_enable_bank.sv
module irqd_enable_bank
  import irqd_pkg::*;
#(
  parameter int unsigned NUM_LINES = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 set_stb,
  input  logic                 clr_stb,
  input  logic [NUM_LINES-1:0] wbits,
  output logic [NUM_LINES-1:0] en_q
);

  logic [NUM_LINES-1:0] en_d;
  logic                 en_touch;

  assign en_touch = set_stb | clr_stb;

  always_comb begin
    for (int k = 0; k < NUM_LINES; k++) begin
      en_d[k] = next_enable(en_q[k], wbits[k], set_stb, clr_stb);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        en_q <= '0;
    else if (en_touch) en_q <= en_d;
  end

  AST_LOWER_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_stb |=> ((en_q & $past(wbits)) == '0)); // R2

  AST_LOWER_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_stb |=> ((en_q & ~$past(wbits)) == ($past(en_q) & ~$past(wbits)))); // R2

  AST_RAISE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    set_stb |=> ((en_q & $past(wbits)) == $past(wbits))); // R3

  AST_RAISE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    set_stb |=> ((en_q & ~$past(wbits)) == ($past(en_q) & ~$past(wbits)))); // R3

  AST_EN_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !en_touch |=> $stable(en_q)); // R2

endmodule

// File: rtl/irqd_route_bank.sv
module irqd_route_bank #(
  parameter int unsigned NUM_LINES = 8,
  parameter int unsigned NUM_CORES = 4,
  parameter int unsigned DATA_W    = 32
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NUM_LINES-1:0]           route_stb,
  input  logic [DATA_W-1:0]              wdata,
  output logic [NUM_LINES*NUM_CORES-1:0] route_flat
);

  localparam logic [NUM_CORES-1:0] ROUTE_RST = NUM_CORES'(1);

  logic [NUM_CORES-1:0] route_q [NUM_LINES];

  // Keeps only the bits that name an existing core.
  function automatic logic [NUM_CORES-1:0] clip_route(input logic [DATA_W-1:0] d);
    return d[NUM_CORES-1:0];
  endfunction

  for (genvar k = 0; k < NUM_LINES; k++) begin : g_line
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            route_q[k] <= ROUTE_RST;
      else if (route_stb[k]) route_q[k] <= clip_route(wdata);
    end

    assign route_flat[k*NUM_CORES +: NUM_CORES] = route_q[k];

    AST_ROUTE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !route_stb[k] |=> $stable(route_q[k])); // R5

    AST_ROUTE_HI_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
      (route_stb[k] && (|wdata[DATA_W-1:NUM_CORES])) |=>
        (route_q[k] == $past(wdata[NUM_CORES-1:0]))); // R5
  end

endmodule

// File: rtl/irqd_fanout.sv
module irqd_fanout
  import irqd_pkg::*;
#(
  parameter int unsigned NUM_LINES = 8,
  parameter int unsigned NUM_CORES = 4,
  parameter bit          REG_OUT   = 1'b1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NUM_LINES-1:0]           line_in,
  input  logic [NUM_LINES-1:0]           en,
  input  logic [NUM_LINES*NUM_CORES-1:0] route_flat,
  output logic [NUM_CORES*NUM_LINES-1:0] irq_o
);

  localparam int unsigned OUT_W = NUM_CORES * NUM_LINES;

  // Unregistered delivery matrix, grouped by core.
  logic [OUT_W-1:0] deliver_w;

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    for (genvar k = 0; k < NUM_LINES; k++) begin : g_ln
      assign deliver_w[c*NUM_LINES + k] =
        deliver(line_in[k], en[k], route_flat[k*NUM_CORES + c]);
    end
  end

  if (REG_OUT) begin : g_reg
    logic [OUT_W-1:0] irq_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q <= '0;
      else        irq_q <= deliver_w;
    end

    assign irq_o = irq_q;

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_chk_c
      for (genvar k = 0; k < NUM_LINES; k++) begin : g_chk_k
        AST_OUT_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
          irq_q[c*NUM_LINES + k] |-> $past(en[k])); // R6

        AST_OUT_NEEDS_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
          irq_q[c*NUM_LINES + k] |-> $past(route_flat[k*NUM_CORES + c])); // R8

        AST_OUT_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
          $past(!line_in[k]) |-> !irq_q[c*NUM_LINES + k]); // R10
      end
    end
  end else begin : g_comb
    assign irq_o = deliver_w;
  end

endmodule

// File: rtl/irq_distributor.sv
module irq_distributor
  import irqd_pkg::*;
#(
  parameter int unsigned NUM_LINES = 8,
  parameter int unsigned NUM_CORES = 4,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned ADDR_W    = 5,
  parameter bit          REG_OUT   = 1'b1
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic [NUM_LINES+IPI_LINES-1:0]         ext_irq_i,
  output logic [IPI_LINES-1:0]                   ipi_o,
  input  logic                                   reg_we_i,
  input  logic [ADDR_W-1:0]                      reg_addr_i,
  input  logic [DATA_W-1:0]                      reg_wdata_i,
  output logic [DATA_W-1:0]                      reg_rdata_o,
  output logic [NUM_CORES*NUM_LINES-1:0]         core_irq_o
);

  localparam int unsigned LINE_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;
  localparam int unsigned EXT_W  = NUM_LINES + IPI_LINES;

  acc_kind_e                      kind;
  logic [LINE_W-1:0]              line_idx;
  logic                           clr_stb;
  logic                           set_stb;
  logic [NUM_LINES-1:0]           route_stb;
  logic [NUM_LINES-1:0]           en_q;
  logic [NUM_LINES*NUM_CORES-1:0] route_flat;
  logic [NUM_LINES-1:0]           line_in;

  // Inter-processor inputs bypass the distributor entirely.
  assign ipi_o   = ext_irq_i[IPI_LINES-1:0];
  assign line_in = ext_irq_i[EXT_W-1:IPI_LINES];

  irqd_decode #(
    .ADDR_W    (ADDR_W),
    .NUM_LINES (NUM_LINES),
    .LINE_W    (LINE_W)
  ) u_decode (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we_i),
    .reg_addr  (reg_addr_i),
    .kind      (kind),
    .line_idx  (line_idx),
    .clr_stb   (clr_stb),
    .set_stb   (set_stb),
    .route_stb (route_stb)
  );

  irqd_enable_bank #(
    .NUM_LINES (NUM_LINES)
  ) u_enable (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_stb (set_stb),
    .clr_stb (clr_stb),
    .wbits   (reg_wdata_i[NUM_LINES-1:0]),
    .en_q    (en_q)
  );

  irqd_route_bank #(
    .NUM_LINES (NUM_LINES),
    .NUM_CORES (NUM_CORES),
    .DATA_W    (DATA_W)
  ) u_route (
    .clk        (clk),
    .rst_n      (rst_n),
    .route_stb  (route_stb),
    .wdata      (reg_wdata_i),
    .route_flat (route_flat)
  );

  irqd_fanout #(
    .NUM_LINES (NUM_LINES),
    .NUM_CORES (NUM_CORES),
    .REG_OUT   (REG_OUT)
  ) u_fanout (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_in    (line_in),
    .en         (en_q),
    .route_flat (route_flat),
    .irq_o      (core_irq_o)
  );

  // Read return: both enable views show the enable vector.
  always_comb begin
    reg_rdata_o = '0;
    unique case (kind)
      ACC_EN_CLR, ACC_EN_SET: reg_rdata_o[NUM_LINES-1:0] = en_q;
      ACC_ROUTE:              reg_rdata_o[NUM_CORES-1:0] =
                                route_flat[32'(line_idx)*NUM_CORES +: NUM_CORES];
      default:                reg_rdata_o = '0;
    endcase
  end

endmodule

// File: tb/irq_distributor_tb_top.sv
module irq_distributor_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int N   = 8;
  localparam int C   = 4;
  localparam int DW  = 32;
  localparam int AW  = 5;
  localparam int IPI = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [N+IPI-1:0] ext;
  logic             we;
  logic [AW-1:0]    addr;
  logic [DW-1:0]    wdata;
  logic [DW-1:0]    rdata;
  logic [IPI-1:0]   ipi;
  logic [C*N-1:0]   irq;

  irq_distributor #(
    .NUM_LINES (N), .NUM_CORES (C), .DATA_W (DW), .ADDR_W (AW), .REG_OUT (1'b1)
  ) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .ext_irq_i   (ext),
    .ipi_o       (ipi),
    .reg_we_i    (we),
    .reg_addr_i  (addr),
    .reg_wdata_i (wdata),
    .reg_rdata_o (rdata),
    .core_irq_o  (irq)
  );

  // Reference state kept by the bench
  logic [N-1:0] m_en;
  logic [C-1:0] m_route [N];

  typedef struct {
    logic [C*N-1:0] irq;
    logic [IPI-1:0] ipi;
    logic [DW-1:0]  rd;
    string          req;
  } item_t;

  item_t sb_q[$];
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  function automatic logic [C*N-1:0] model_irq();
    logic [C*N-1:0] e;
    e = '0;
    for (int k = 0; k < N; k++) begin
      for (int c = 0; c < C; c++) begin
        if (ext[k+IPI] && m_en[k] && m_route[k][c]) e[c*N+k] = 1'b1;
      end
    end
    return e;
  endfunction

  function automatic logic [DW-1:0] model_read(input logic [AW-1:0] a);
    logic [DW-1:0] r;
    int ia;
    r  = '0;
    ia = int'(a);
    if (ia == 0 || ia == 1)          r[N-1:0] = m_en;
    else if (ia >= 2 && ia < 2 + N)  r[C-1:0] = m_route[ia-2];
    return r;
  endfunction

  task automatic compare(input string req, input string what,
                         input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Monitor: pops one expected item per falling edge and compares.
  initial begin : monitor
    item_t it;
    forever begin
      @(negedge clk);
      if (sb_q.size() > 0) begin
        it = sb_q[0];
        compare(it.req, "core_irq", DW'(irq), DW'(it.irq));
        compare(it.req, "ipi",      DW'(ipi), DW'(it.ipi));
        compare(it.req, "rdata",    rdata,    it.rd);
        void'(sb_q.pop_front());
      end
    end
  end

  // Driver side: queue the expected view after the given number of edges.
  task automatic expect_after(input int edges, input string req);
    item_t it;
    repeat (edges) @(posedge clk);
    #1;
    it.irq = model_irq();
    it.ipi = ext[IPI-1:0];
    it.rd  = model_read(addr);
    it.req = req;
    sb_q.push_back(it);
    wait (sb_q.size() == 0);
  endtask

  task automatic reg_write(input logic [AW-1:0] a, input logic [DW-1:0] d,
                           input string req);
    int ia;
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
    ia = int'(a);
    if (ia == 0)                    m_en = m_en & ~d[N-1:0];
    else if (ia == 1)               m_en = m_en | d[N-1:0];
    else if (ia >= 2 && ia < 2 + N) m_route[ia-2] = d[C-1:0];
    expect_after(1, req);
  endtask

  task automatic read_at(input logic [AW-1:0] a, input string req);
    @(negedge clk);
    addr = a;
    expect_after(1, req);
  endtask

  task automatic drive_ext(input logic [N+IPI-1:0] v, input int edges, input string req);
    @(negedge clk);
    ext = v;
    expect_after(edges, req);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL run watchdog: actual=hung expected=complete");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : stimulus
    ext = '0; we = 1'b0; addr = '0; wdata = '0;
    m_en = '0;
    for (int k = 0; k < N; k++) m_route[k] = C'(1);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state of enables, masks and outputs
    expect_after(1, "R1");
    read_at(5'd2, "R1");
    read_at(5'd9, "R1");

    // R6: all lines high, nothing enabled
    drive_ext({{N{1'b1}}, 2'b00}, 2, "R6");

    // R3 / R4: raise view with high junk bits
    reg_write(5'd1, 32'hFFFF_FFA5, "R3");
    read_at(5'd0, "R4");

    // R2: lower view clears only its set bits
    reg_write(5'd0, 32'h0000_0021, "R2");
    read_at(5'd1, "R4");

    // R5: steer line 2 to core 2, high bits dropped
    reg_write(5'd4, 32'hFFFF_FFF4, "R5");
    reg_write(5'd2, 32'h0000_0002, "R5");
    reg_write(5'd1, 32'h0000_00FF, "R3");

    // R6: alternating line pattern
    drive_ext({8'b1010_1010, 2'b00}, 2, "R6");
    drive_ext({8'b0101_0101, 2'b00}, 2, "R6");

    // R8: broadcast mask on line 7, empty mask on line 3
    reg_write(5'd9, 32'h0000_000F, "R8");
    reg_write(5'd5, 32'h0000_0000, "R8");
    drive_ext({{N{1'b1}}, 2'b00}, 2, "R8");

    // R7: inter-processor inputs only
    drive_ext({{N{1'b1}}, 2'b11}, 2, "R7");
    drive_ext({{N{1'b1}}, 2'b01}, 2, "R7");
    drive_ext({{N{1'b0}}, 2'b10}, 2, "R7");
    drive_ext({{N{1'b1}}, 2'b00}, 2, "R7");

    // R9: unmapped offsets
    reg_write(5'd20, 32'hFFFF_FFFF, "R9");
    reg_write(5'd10, 32'h0000_0000, "R9");
    read_at(5'd1, "R9");
    read_at(5'd9, "R9");
    read_at(5'd31, "R9");

    // R10: release after exactly one edge, then reassert
    drive_ext({{N{1'b0}}, 2'b00}, 1, "R10");
    drive_ext({8'b1100_0011, 2'b00}, 1, "R6");
    drive_ext({8'b0100_0001, 2'b00}, 1, "R10");

    // R2: lower all lines
    reg_write(5'd0, 32'h0000_00FF, "R2");
    read_at(5'd1, "R4");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule